// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces one interrupt flag for each side of a shared two-port memory with 8K locations of 8 bits. The two ports can reach any location independently. Each port presents a 13-bit address, an active-low select, a read/write strobe (high for read, low for write) and an active-low output enable. The two highest addresses act as mailboxes. A port writes its 8-bit message into the mailbox of the other side, and that raises the other side's interrupt. The receiving side clears its interrupt by reading its own mailbox. The message bytes stay in the ordinary memory array, which is outside this block. This block only watches the port strobes and keeps the two flags.

The block has one enable input. When it is low, the mailbox function is off: both flags are held inactive and the two top addresses are ordinary memory. Every strobe is sampled on the rising clock edge, and each flag is a register. A flag therefore changes on the first clock edge after the access that causes the change. The block has no data stream, so all of its pins are plain control and status signals with no handshake.

Top module: `mbx_irq_top`

## Requirements
- R1: After reset, both `l_irq_n` and `r_irq_n` are high (inactive).
- R2: When the enable is high and the right port writes (`r_cs_n`=0, `r_rw_n`=0) to address 0x1FFE, `l_irq_n` is low after the next rising edge.
- R3: When the enable is high and the left port writes (`l_cs_n`=0, `l_rw_n`=0) to address 0x1FFF, `r_irq_n` is low after the next rising edge.
- R4: An access by the left port to 0x1FFE with `l_cs_n`=0 and `l_oe_n`=0 drives `l_irq_n` high after the next edge, whatever the level of `l_rw_n`.
- R5: An access by the right port to 0x1FFF with `r_cs_n`=0 and `r_oe_n`=0 drives `r_irq_n` high after the next edge, whatever the level of `r_rw_n`.
- R6: If the set and the clear of the same flag happen in the same cycle, the flag ends up active.
- R7: A port that writes to its own incoming mailbox address while its output enable is high leaves its own flag unchanged.
- R8: While the enable is low, both flags are high after the next edge, and no write to 0x1FFE or 0x1FFF sets a flag.
- R9: Accesses to any other address, reads of the other side's mailbox, and strobes given while the select is high leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbx_en | input | 1 | Mailbox function enable |
| l_cs_n | input | 1 | Left port select, active low |
| l_rw_n | input | 1 | Left port read/write (0 = write) |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | 13 | Left port address |
| r_cs_n | input | 1 | Right port select, active low |
| r_rw_n | input | 1 | Right port read/write (0 = write) |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | 13 | Right port address |
| l_irq_n | output | 1 | Interrupt toward the left port, active low |
| r_irq_n | output | 1 | Interrupt toward the right port, active low |

## Verification
The flags are driven with single posts from each side and with posts from both sides in the same cycle. Accesses that come close to matching a mailbox are applied next: neighbouring addresses, reads of the other side's mailbox, strobes with the select high, and writes to a port's own mailbox. These show that only the exact write or read condition moves a flag. A clear that carries a write level, and a clear that lands in the same cycle as a set, show that the read/write strobe is ignored for clears and that a set wins over a clear. Turning the enable off while both flags are pending, and then posting, shows that disabling drops the pending flags and suppresses new ones.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int unsigned MBX_ADDR_W = 13;
  parameter int unsigned MBX_SIDES  = 2;

  typedef struct packed {
    logic cs_n;
    logic rw_n;
    logic oe_n;
  } mbx_ctl_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = MBX_ADDR_W,
  parameter logic [ADDR_W-1:0] IN_BOX  = '1,
  parameter logic [ADDR_W-1:0] OUT_BOX = '1
) (
  input  mbx_ctl_t          ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic              post,
  output logic              take
);
  // post: a write into the other side's mailbox
  // take: a selected, output-enabled access to this side's own mailbox
  always_comb begin
    post = !ctl.cs_n && !ctl.rw_n && (addr == OUT_BOX);
    take = !ctl.cs_n && !ctl.oe_n && (addr == IN_BOX);
  end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= 1'b0;
    else if (!en)   pend <= 1'b0;
    else if (set)   pend <= 1'b1;
    else if (clr)   pend <= 1'b0;
  end

  assign irq_n = ~pend;

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set) |=> !irq_n);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set && clr) |=> irq_n);
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> irq_n);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = MBX_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbx_en,
  input  logic              l_cs_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_cs_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] L_BOX    = TOP_ADDR - 1'b1;
  localparam logic [ADDR_W-1:0] R_BOX    = TOP_ADDR;

  mbx_ctl_t          ctl  [MBX_SIDES];
  logic [ADDR_W-1:0] addr [MBX_SIDES];
  logic [MBX_SIDES-1:0] post, take, irq_n;

  assign ctl[0]  = '{cs_n: l_cs_n, rw_n: l_rw_n, oe_n: l_oe_n};
  assign ctl[1]  = '{cs_n: r_cs_n, rw_n: r_rw_n, oe_n: r_oe_n};
  assign addr[0] = l_addr;
  assign addr[1] = r_addr;

  // side 0 = left (receives at L_BOX), side 1 = right (receives at R_BOX)
  for (genvar s = 0; s < MBX_SIDES; s++) begin : g_side
    localparam logic [ADDR_W-1:0] IN_B  = (s == 0) ? L_BOX : R_BOX;
    localparam logic [ADDR_W-1:0] OUT_B = (s == 0) ? R_BOX : L_BOX;

    mbx_port_decode #(.ADDR_W(ADDR_W), .IN_BOX(IN_B), .OUT_BOX(OUT_B)) u_dec (
      .ctl  (ctl[s]),
      .addr (addr[s]),
      .post (post[s]),
      .take (take[s])
    );

    mbx_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mbx_en),
      .set   (post[MBX_SIDES-1-s]),
      .clr   (take[s]),
      .irq_n (irq_n[s])
    );
  end

  assign l_irq_n = irq_n[0];
  assign r_irq_n = irq_n[1];

  p_left_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_en && !r_cs_n && !r_rw_n && r_addr == L_BOX) |=> !l_irq_n);
  p_right_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_en && !l_cs_n && !l_rw_n && l_addr == R_BOX) |=> !r_irq_n);
  p_right_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_en && !r_cs_n && !r_oe_n && r_addr == R_BOX &&
     !(!l_cs_n && !l_rw_n && l_addr == R_BOX)) |=> r_irq_n);
  p_own_write_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mbx_en && !l_cs_n && !l_rw_n && l_oe_n && l_addr == L_BOX &&
     !(!r_cs_n && !r_rw_n && r_addr == L_BOX)) |=> $stable(l_irq_n));
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (l_irq_n && r_irq_n));
endmodule

// File: tb/mbx_irq_top_tb_top.sv
module mbx_irq_top_tb_top;
  localparam int AW = 13;
  localparam logic [AW-1:0] LB = 13'h1FFE;
  localparam logic [AW-1:0] RB = 13'h1FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mbx_en = 1'b1;
  logic l_cs_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
  logic r_cs_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int fails = 0;
  logic m_l = 1'b0, m_r = 1'b0;
  logic [1:0] q_exp [$];
  string      q_tag [$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  mbx_irq_top dut_i (
    .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
    .l_cs_n(l_cs_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .r_cs_n(r_cs_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {l_irq_n,r_irq_n} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of strobes, model the flags, queue the expectation
  task automatic drive(string tag, logic en,
                       logic lcs, logic lrw, logic loe, logic [AW-1:0] la,
                       logic rcs, logic rrw, logic roe, logic [AW-1:0] ra);
    logic lset, lclr, rset, rclr;
    @(negedge clk);
    mbx_en = en;
    l_cs_n = lcs; l_rw_n = lrw; l_oe_n = loe; l_addr = la;
    r_cs_n = rcs; r_rw_n = rrw; r_oe_n = roe; r_addr = ra;
    lset = !rcs && !rrw && ra == LB;
    lclr = !lcs && !loe && la == LB;
    rset = !lcs && !lrw && la == RB;
    rclr = !rcs && !roe && ra == RB;
    if (!en) m_l = 1'b0; else if (lset) m_l = 1'b1; else if (lclr) m_l = 1'b0;
    if (!en) m_r = 1'b0; else if (rset) m_r = 1'b1; else if (rclr) m_r = 1'b0;
    @(posedge clk);
    q_exp.push_back({~m_l, ~m_r});
    q_tag.push_back(tag);
  endtask

  task automatic idle(string tag);
    drive(tag, 1'b1, 1, 1, 1, 13'h0, 1, 1, 1, 13'h0);
  endtask

  // monitor: compare queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (q_exp.size() > 0) begin
        logic [1:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(t, {l_irq_n, r_irq_n}, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {l_irq_n, r_irq_n}, 2'b11);
    rst_n = 1'b1;
    idle("R1 idle after reset");
    // R2: right posts to left mailbox
    drive("R2 right write 1FFE", 1, 1,1,1,13'h0, 0,0,1,LB);
    // R9: near misses
    drive("R9 right write 1FFD", 1, 1,1,1,13'h0, 0,0,1,13'h1FFD);
    drive("R9 left read 1FFD", 1, 0,1,0,13'h1FFD, 1,1,1,13'h0);
    drive("R9 right read 1FFE", 1, 1,1,1,13'h0, 0,1,0,LB);
    drive("R9 left strobes cs high", 1, 1,0,0,LB, 1,1,1,13'h0);
    // R7: left writes its own mailbox, output enable high
    drive("R7 left own write", 1, 0,0,1,LB, 1,1,1,13'h0);
    // R4: clear with write level on rw
    drive("R4 left clear rw low", 1, 0,0,0,LB, 1,1,1,13'h0);
    // R3: left posts to right mailbox
    drive("R3 left write 1FFF", 1, 0,0,1,RB, 1,1,1,13'h0);
    drive("R7 right own write", 1, 1,1,1,13'h0, 0,0,1,RB);
    drive("R9 left read 1FFF", 1, 0,1,0,RB, 1,1,1,13'h0);
    drive("R5 right read 1FFF", 1, 1,1,1,13'h0, 0,1,0,RB);
    // R6: set and clear together
    drive("R2 set left", 1, 1,1,1,13'h0, 0,0,1,LB);
    drive("R6 left set+clear", 1, 0,1,0,LB, 0,0,1,LB);
    drive("R4 left clear read", 1, 0,1,0,LB, 1,1,1,13'h0);
    drive("R3 set right", 1, 0,0,1,RB, 1,1,1,13'h0);
    drive("R6 right set+clear", 1, 0,0,1,RB, 0,1,0,RB);
    drive("R5 right clear rw low", 1, 1,1,1,13'h0, 0,0,0,RB);
    // both posted at once, then disable
    drive("R2 R3 both posts", 1, 0,0,1,RB, 0,0,1,LB);
    drive("R8 disable drops flags", 0, 1,1,1,13'h0, 1,1,1,13'h0);
    drive("R8 disabled posts ignored", 0, 0,0,1,RB, 0,0,1,LB);
    idle("R8 re-enabled idle");
    idle("R9 idle hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule